// File: doc/BRIEF.md
# Codec Job Control and Interrupt Registers

This block is the host-facing control and status front end of a line-oriented image codec engine. Software writes command bits over a small register bus. It can start a job, choose whether the job ends or only pauses when the programmed number of lines is done, request an initialisation pulse and open access to the context table. The block counts the lines that the datapath finishes and tells the datapath when it may run. It turns the datapath's events into sticky status flags, and it drives one interrupt line from the flags that software has enabled.

A job can also stop while it is running. When the marker-halt enable is set and the datapath reports a marker, the job halts and waits. Clearing the enable lets it continue towards the same line target. Software may change the line target of a running job under a guarded rule: the register must first hold the all-ones value, and then it accepts exactly one other value.

Register map (address: contents). 0: bit 0 writes a soft reset and reads as 0. 1: command, with bit 0 init pulse (reads 0), bit 1 job start/run, bit 2 context access, bit 3 pause-select. 2: status. 3: interrupt enables in bits 0 to 3 and marker-halt in bit 7. 4 and 5: line target, low and high byte. 6 and 7: lines done, low and high byte. Every other address reads 0.

Top module: `jobctl_regs`

## Requirements
- R1: After the reset input, or one cycle after a write to address 0 with bit 0 set, the block is in its reset state. In that state run_o, irq_o, init_o and ctx_acc_o are 0, all command, status and enable bits are 0, the line target reads 0xFFFF and the line counter reads 0.
- R2: Status (address 2) holds job done in bit 0, data ready in bit 1, marker seen in bit 2, interrupt pending in bit 3, stuffing overflow in bit 4 and paused in bit 5. An event input sets its bit one cycle after it is sampled. Writing 1 to a bit clears it. A set and a clear in the same cycle leave the bit set.
- R3: Enable bits 0, 1, 2 and 3 (address 3) gate (done OR paused), data ready, marker seen and stuffing overflow. irq_o and status bit 3 are 1 while any gated source is 1. Changing the enables leaves the status bits unchanged.
- R4: Writing 1 to command bit 1 while no job runs starts a job. run_o goes high on the next cycle, the line counter goes to 0, and done and paused are cleared. Writing 1 while a job runs has no further effect.
- R5: Each line_done_i sampled while run_o is 1 increments the line counter (addresses 6 and 7) by one.
- R6: With command bit 3 at 0, the line that brings the counter to the target clears command bit 1 and run_o on the next cycle and sets done.
- R7: With command bit 3 at 1, that line clears command bit 1 and run_o, sets paused and leaves done at 0. A new start write resumes the job with the counter at 0.
- R8: A write to address 4 only stages the low byte. A write to address 5 commits {high byte, staged byte}. A commit of 0 is ignored. While a job runs, a commit is accepted only if it is 0xFFFF or if the last accepted value was 0xFFFF. Otherwise the target is unchanged.
- R9: With enable bit 7 set, a marker sampled while running drops run_o on the next cycle. Writing enable bit 7 as 0 raises run_o again on the next cycle.
- R10: A stuffing overflow event sets its status bit and does not stop the job.
- R11: Command bit 0 gives a one-cycle init_o pulse on the next cycle. Command bit 2 drives ctx_acc_o as a level. Address 1 reads back bits 1 to 3.
- R12: line_done_i sampled while run_o is 0 leaves the line counter unchanged.
- R13: Writing command bit 1 as 0 during a job stops it on the next cycle. Done and paused do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| line_done_i | input | 1 | Datapath finished one line |
| marker_i | input | 1 | Datapath found a marker |
| data_rdy_i | input | 1 | Datapath data buffer ready |
| ovf_i | input | 1 | Stuffing counter overflow |
| run_o | output | 1 | Job may proceed |
| init_o | output | 1 | One-cycle initialisation request |
| ctx_acc_o | output | 1 | Context table access enable |
| irq_o | output | 1 | Interrupt request |

## Verification
Every register updates on the rising edge that samples a write or an event. Status bits, the counter, run_o and init_o therefore change one cycle after the stimulus. irq_o and the pending bit follow the registered status and enables in that same cycle. rdata_o is combinational from addr_i and the stored state. The bench drives inputs at the falling edge, steps a behavioural model on the rising edge, and compares every output 1 ns after each rising edge. Each comparison therefore sees exactly the state one sampling edge after its stimulus.

// File: rtl/jobctl_pkg.sv
`timescale 1ns/1ps
package jobctl_pkg;
    typedef enum logic [3:0] {
        A_SYS    = 4'd0,
        A_CMD    = 4'd1,
        A_STAT   = 4'd2,
        A_IEN    = 4'd3,
        A_LEN_LO = 4'd4,
        A_LEN_HI = 4'd5,
        A_CNT_LO = 4'd6,
        A_CNT_HI = 4'd7
    } reg_addr_e;

    localparam int CMD_INIT  = 0;
    localparam int CMD_RUN   = 1;
    localparam int CMD_CTX   = 2;
    localparam int CMD_PAUSE = 3;
    localparam int IEN_MHALT = 7;
    localparam int N_SRC     = 4;

    typedef struct packed {
        logic jc;
        logic jp;
        logic rc;
        logic init;
        logic mk;
    } seq_t;

    typedef struct packed {
        logic js;
        logic ds;
        logic ms;
        logic sc;
        logic ps;
        logic [N_SRC-1:0] en;
        logic mh;
    } stat_t;
endpackage

// File: rtl/jobctl_seq.sv
`timescale 1ns/1ps
module jobctl_seq
    import jobctl_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       soft_rst_i,
    input  logic       cmd_wr_i,
    input  logic [3:0] cmd_i,
    input  logic       reach_i,
    input  logic       marker_i,
    input  logic       mhalt_i,
    output logic       run_o,
    output logic       jc_o,
    output logic       jp_o,
    output logic       rc_o,
    output logic       init_o,
    output logic       start_o,
    output logic       end_o,
    output logic       pause_o
);
    seq_t q, d;

    always_comb begin
        d       = q;
        d.init  = 1'b0;
        start_o = 1'b0;
        end_o   = 1'b0;
        pause_o = 1'b0;
        if (cmd_wr_i) begin
            d.jp   = cmd_i[CMD_PAUSE];
            d.rc   = cmd_i[CMD_CTX];
            d.init = cmd_i[CMD_INIT];
            if (cmd_i[CMD_RUN] && !q.jc) begin
                d.jc    = 1'b1;
                d.mk    = 1'b0;
                start_o = 1'b1;
            end else if (!cmd_i[CMD_RUN]) begin
                d.jc = 1'b0;
            end
        end else if (reach_i) begin
            d.jc = 1'b0;
            if (q.jp) pause_o = 1'b1;
            else      end_o   = 1'b1;
        end
        if (marker_i && q.jc && mhalt_i) d.mk = 1'b1;
        if (!mhalt_i || !d.jc)           d.mk = 1'b0;
        if (soft_rst_i) begin
            d       = '0;
            start_o = 1'b0;
            end_o   = 1'b0;
            pause_o = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign run_o  = q.jc && !q.mk;
    assign jc_o   = q.jc;
    assign jp_o   = q.jp;
    assign rc_o   = q.rc;
    assign init_o = q.init;

    // R4
    start_runs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_wr_i && cmd_i[CMD_RUN] && !q.jc && !soft_rst_i |=> run_o);
    // R6
    count_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reach_i && !cmd_wr_i && !soft_rst_i |=> !q.jc);
    // R9
    marker_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        marker_i && run_o && mhalt_i && !soft_rst_i |=> !run_o);
endmodule

// File: rtl/jobctl_stat.sv
`timescale 1ns/1ps
module jobctl_stat
    import jobctl_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             soft_rst_i,
    input  logic             stat_wr_i,
    input  logic [4:0]       clr_i,
    input  logic             ien_wr_i,
    input  logic [N_SRC:0]   ien_i,
    input  logic             start_i,
    input  logic             end_i,
    input  logic             pause_i,
    input  logic             rdy_i,
    input  logic             marker_i,
    input  logic             ovf_i,
    output logic [4:0]       flags_o,
    output logic [N_SRC-1:0] en_o,
    output logic             mh_o,
    output logic             irq_o
);
    stat_t q, d;
    logic [N_SRC-1:0] src;

    always_comb begin
        d = q;
        if (stat_wr_i) begin
            if (clr_i[0]) d.js = 1'b0;
            if (clr_i[1]) d.ds = 1'b0;
            if (clr_i[2]) d.ms = 1'b0;
            if (clr_i[3]) d.sc = 1'b0;
            if (clr_i[4]) d.ps = 1'b0;
        end
        if (start_i) begin
            d.js = 1'b0;
            d.ps = 1'b0;
        end
        if (end_i) begin
            d.js = 1'b1;
            d.ps = 1'b0;
        end
        if (pause_i)  d.ps = 1'b1;
        if (rdy_i)    d.ds = 1'b1;
        if (marker_i) d.ms = 1'b1;
        if (ovf_i)    d.sc = 1'b1;
        if (ien_wr_i) begin
            d.en = ien_i[N_SRC-1:0];
            d.mh = ien_i[N_SRC];
        end
        if (soft_rst_i) d = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign src     = {q.sc, q.ms, q.ds, q.js | q.ps};
    assign irq_o   = |(src & q.en);
    assign flags_o = {q.ps, q.sc, q.ms, q.ds, q.js};
    assign en_o    = q.en;
    assign mh_o    = q.mh;

    // R2
    done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_wr_i && clr_i[0] && !end_i && !soft_rst_i |=> !q.js);
    // R2
    ready_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdy_i && !soft_rst_i |=> q.ds);
    // R7
    pause_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pause_i && !soft_rst_i |=> q.ps && !q.js);
    // R10
    ovf_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_i && !soft_rst_i |=> q.sc);
endmodule

// File: rtl/jobctl_linecnt.sv
`timescale 1ns/1ps
module jobctl_linecnt #(
    parameter int DATA_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                soft_rst_i,
    input  logic                wr_lo_i,
    input  logic                wr_hi_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic                busy_i,
    input  logic                start_i,
    input  logic                count_en_i,
    output logic [2*DATA_W-1:0] lset_o,
    output logic [2*DATA_W-1:0] cnt_o,
    output logic                reach_o
);
    localparam int LINE_W = 2 * DATA_W;
    localparam logic [LINE_W-1:0] LMAX = '1;

    typedef struct packed {
        logic [LINE_W-1:0] lset;
        logic [LINE_W-1:0] cnt;
        logic [DATA_W-1:0] stage;
        logic              arm;
    } lc_t;

    localparam lc_t LC_RST = '{lset: LMAX, cnt: '0, stage: '0, arm: 1'b1};

    lc_t q, d;
    logic [LINE_W-1:0] cand;
    logic [LINE_W:0]   nxt;
    logic              take;

    always_comb begin
        d       = q;
        cand    = {wdata_i, q.stage};
        nxt     = {1'b0, q.cnt} + 1'b1;
        take    = wr_hi_i && (cand != '0) && (!busy_i || cand == LMAX || q.arm);
        reach_o = count_en_i && (nxt >= {1'b0, q.lset});
        if (start_i)         d.cnt = '0;
        else if (count_en_i) d.cnt = nxt[LINE_W-1:0];
        if (wr_lo_i) d.stage = wdata_i;
        if (take) begin
            d.lset = cand;
            d.arm  = (cand == LMAX);
        end
        if (soft_rst_i) begin
            d       = LC_RST;
            reach_o = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= LC_RST;
        else         q <= d;
    end

    assign lset_o = q.lset;
    assign cnt_o  = q.cnt;

    // R8
    lset_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.lset != '0);
    // R8
    rewrite_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_hi_i && busy_i && !q.arm && ({wdata_i, q.stage} != LMAX) |=> $stable(q.lset));
    // R12
    idle_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !count_en_i && !start_i && !soft_rst_i |=> $stable(q.cnt));
endmodule

// File: rtl/jobctl_regs.sv
`timescale 1ns/1ps
module jobctl_regs
    import jobctl_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              line_done_i,
    input  logic              marker_i,
    input  logic              data_rdy_i,
    input  logic              ovf_i,
    output logic              run_o,
    output logic              init_o,
    output logic              ctx_acc_o,
    output logic              irq_o
);
    localparam int LINE_W = 2 * DATA_W;

    logic wr_sys, wr_cmd, wr_stat, wr_ien, wr_lo, wr_hi;
    logic soft_rst, mh_eff;
    logic jc, jp, start_p, end_p, pause_p, reach;
    logic [4:0]       flags;
    logic [N_SRC-1:0] en;
    logic             mh;
    logic [LINE_W-1:0] lset, cnt;

    assign wr_sys   = wr_en_i && (addr_i == ADDR_W'(A_SYS));
    assign wr_cmd   = wr_en_i && (addr_i == ADDR_W'(A_CMD));
    assign wr_stat  = wr_en_i && (addr_i == ADDR_W'(A_STAT));
    assign wr_ien   = wr_en_i && (addr_i == ADDR_W'(A_IEN));
    assign wr_lo    = wr_en_i && (addr_i == ADDR_W'(A_LEN_LO));
    assign wr_hi    = wr_en_i && (addr_i == ADDR_W'(A_LEN_HI));
    assign soft_rst = wr_sys && wdata_i[0];
    assign mh_eff   = wr_ien ? wdata_i[IEN_MHALT] : mh;

    jobctl_seq u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_rst_i (soft_rst),
        .cmd_wr_i   (wr_cmd),
        .cmd_i      (wdata_i[3:0]),
        .reach_i    (reach),
        .marker_i   (marker_i),
        .mhalt_i    (mh_eff),
        .run_o      (run_o),
        .jc_o       (jc),
        .jp_o       (jp),
        .rc_o       (ctx_acc_o),
        .init_o     (init_o),
        .start_o    (start_p),
        .end_o      (end_p),
        .pause_o    (pause_p)
    );

    jobctl_stat u_stat (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_rst_i (soft_rst),
        .stat_wr_i  (wr_stat),
        .clr_i      ({wdata_i[5:4], wdata_i[2:0]}),
        .ien_wr_i   (wr_ien),
        .ien_i      ({wdata_i[IEN_MHALT], wdata_i[N_SRC-1:0]}),
        .start_i    (start_p),
        .end_i      (end_p),
        .pause_i    (pause_p),
        .rdy_i      (data_rdy_i),
        .marker_i   (marker_i),
        .ovf_i      (ovf_i),
        .flags_o    (flags),
        .en_o       (en),
        .mh_o       (mh),
        .irq_o      (irq_o)
    );

    jobctl_linecnt #(.DATA_W(DATA_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .soft_rst_i (soft_rst),
        .wr_lo_i    (wr_lo),
        .wr_hi_i    (wr_hi),
        .wdata_i    (wdata_i),
        .busy_i     (jc),
        .start_i    (start_p),
        .count_en_i (line_done_i && run_o),
        .lset_o     (lset),
        .cnt_o      (cnt),
        .reach_o    (reach)
    );

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(A_CMD): begin
                rdata_o[CMD_RUN]   = jc;
                rdata_o[CMD_CTX]   = ctx_acc_o;
                rdata_o[CMD_PAUSE] = jp;
            end
            ADDR_W'(A_STAT):   rdata_o[5:0] = {flags[4:3], irq_o, flags[2:0]};
            ADDR_W'(A_IEN): begin
                rdata_o[N_SRC-1:0] = en;
                rdata_o[IEN_MHALT] = mh;
            end
            ADDR_W'(A_LEN_LO): rdata_o = lset[DATA_W-1:0];
            ADDR_W'(A_LEN_HI): rdata_o = lset[LINE_W-1:DATA_W];
            ADDR_W'(A_CNT_LO): rdata_o = cnt[DATA_W-1:0];
            ADDR_W'(A_CNT_HI): rdata_o = cnt[LINE_W-1:DATA_W];
            default:           rdata_o = '0;
        endcase
    end

    // R3
    irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (|flags));
    // R10
    ovf_keeps_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_i && run_o && !wr_en_i && !line_done_i && !marker_i |=> run_o);
endmodule

// File: tb/sim_jobctl_regs.sv
`timescale 1ns/1ps
module sim_jobctl_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd2;
    logic [7:0] wdata = 8'd0;
    logic       line_done = 1'b0, marker = 1'b0, data_rdy = 1'b0, ovf = 1'b0;
    logic [7:0] rdata;
    logic       run, init, ctx, irq;

    int n_cmp = 0, n_bad = 0;
    string tag = "R1 reset";
    logic [3:0] watch = 4'd2;
    bit armed = 0;

    // behavioural model state
    int m_jc, m_jp, m_rc, m_init, m_mk;
    int m_js, m_ds, m_ms, m_sc, m_ps, m_en, m_mh;
    int m_lset, m_stage, m_arm, m_cnt;

    always #2 clk = ~clk;

    jobctl_regs u0 (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .line_done_i(line_done), .marker_i(marker), .data_rdy_i(data_rdy),
        .ovf_i(ovf), .run_o(run), .init_o(init), .ctx_acc_o(ctx), .irq_o(irq)
    );

    function automatic void m_reset();
        m_jc = 0; m_jp = 0; m_rc = 0; m_init = 0; m_mk = 0;
        m_js = 0; m_ds = 0; m_ms = 0; m_sc = 0; m_ps = 0; m_en = 0; m_mh = 0;
        m_lset = 65535; m_stage = 0; m_arm = 1; m_cnt = 0;
    endfunction

    function automatic int m_irq();
        int s;
        s = ((m_js | m_ps) & m_en) | ((m_ds << 1) & m_en) | ((m_ms << 2) & m_en) | ((m_sc << 3) & m_en);
        return (s != 0) ? 1 : 0;
    endfunction

    function automatic int m_read(input logic [3:0] a);
        case (a)
            4'd1: return (m_jp << 3) | (m_rc << 2) | (m_jc << 1);
            4'd2: return (m_ps << 5) | (m_sc << 4) | (m_irq() << 3) | (m_ms << 2) | (m_ds << 1) | m_js;
            4'd3: return (m_mh << 7) | m_en;
            4'd4: return m_lset & 255;
            4'd5: return m_lset >> 8;
            4'd6: return m_cnt & 255;
            4'd7: return m_cnt >> 8;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    initial m_reset();

    always @(posedge clk) begin : mdl
        int mh_eff, runm, cnt_en, reach, start, endp, pause, cand, njc;
        if (!rst_n || (wr_en && addr == 4'd0 && wdata[0])) begin
            m_reset();
        end else begin
            mh_eff = (wr_en && addr == 4'd3) ? int'(wdata[7]) : m_mh;
            runm   = (m_jc != 0 && m_mk == 0) ? 1 : 0;
            cnt_en = (line_done && runm != 0) ? 1 : 0;
            reach  = (cnt_en != 0 && m_cnt + 1 >= m_lset) ? 1 : 0;
            start = 0; endp = 0; pause = 0;
            njc = m_jc;
            m_init = 0;
            if (wr_en && addr == 4'd1) begin
                m_jp = wdata[3]; m_rc = wdata[2]; m_init = wdata[0];
                if (wdata[1] && m_jc == 0) begin njc = 1; start = 1; end
                else if (!wdata[1]) njc = 0;
            end else if (reach != 0) begin
                njc = 0;
                if (m_jp != 0) pause = 1; else endp = 1;
            end
            if (marker && m_jc != 0 && mh_eff != 0) m_mk = 1;
            if (start != 0 || mh_eff == 0 || njc == 0) m_mk = 0;
            m_jc = njc;
            if (wr_en && addr == 4'd2) begin
                if (wdata[0]) m_js = 0;
                if (wdata[1]) m_ds = 0;
                if (wdata[2]) m_ms = 0;
                if (wdata[4]) m_sc = 0;
                if (wdata[5]) m_ps = 0;
            end
            if (start != 0) begin m_js = 0; m_ps = 0; end
            if (endp != 0)  begin m_js = 1; m_ps = 0; end
            if (pause != 0) m_ps = 1;
            if (data_rdy) m_ds = 1;
            if (marker)   m_ms = 1;
            if (ovf)      m_sc = 1;
            if (wr_en && addr == 4'd3) begin m_en = wdata[3:0]; m_mh = wdata[7]; end
            cand = (int'(wdata) << 8) | m_stage;
            if (start != 0) m_cnt = 0;
            else if (cnt_en != 0) m_cnt = m_cnt + 1;
            if (wr_en && addr == 4'd4) m_stage = wdata;
            if (wr_en && addr == 4'd5 && cand != 0 &&
                (!(njc != 0 || start == 0 && m_jc != 0) || cand == 65535 || m_arm != 0)) begin
                m_lset = cand;
                m_arm  = (cand == 65535) ? 1 : 0;
            end
        end
        #1;
        if (armed) begin
            chk("run_o", run, (m_jc != 0 && m_mk == 0) ? 1 : 0);
            chk("irq_o", irq, m_irq());
            chk("init_o", init, m_init);
            chk("ctx_acc_o", ctx, m_rc);
            chk($sformatf("rdata@%0d", addr), rdata, m_read(addr));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; addr = watch; wdata = 8'd0;
    endtask

    task automatic look(input logic [3:0] a, input int n);
        @(negedge clk); watch = a; addr = a;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ev(input logic l, input logic m, input logic r, input logic o);
        @(negedge clk); line_done = l; marker = m; data_rdy = r; ovf = o;
        @(negedge clk); line_done = 0; marker = 0; data_rdy = 0; ovf = 0;
    endtask

    task automatic stimulus();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        armed = 1;
        tag = "R1 reset";
        look(4'd4, 2); look(4'd5, 1); look(4'd6, 1); look(4'd1, 1); look(4'd3, 1);

        tag = "R2 status";
        look(4'd2, 1);
        ev(0, 0, 1, 0); ev(0, 1, 0, 0); ev(0, 0, 0, 1);
        wr(4'd2, 8'h02);
        @(negedge clk); data_rdy = 1; wr_en = 1; addr = 4'd2; wdata = 8'h02;
        @(negedge clk); data_rdy = 0; wr_en = 0; addr = watch; wdata = 0;
        look(4'd2, 2);

        tag = "R3 irq";
        wr(4'd3, 8'h0F); look(4'd2, 2);
        wr(4'd3, 8'h00); look(4'd2, 2);
        wr(4'd3, 8'h04); look(4'd2, 1);
        wr(4'd2, 8'hFF); look(4'd2, 1);

        tag = "R11 init/ctx";
        look(4'd1, 1);
        wr(4'd1, 8'h05); look(4'd1, 2);
        wr(4'd1, 8'h00); look(4'd1, 1);

        tag = "R8 target";
        wr(4'd4, 8'h03); look(4'd4, 1); look(4'd5, 1);
        wr(4'd5, 8'h00); look(4'd4, 1);

        tag = "R4 start";
        wr(4'd3, 8'h01);
        look(4'd6, 1);
        wr(4'd1, 8'h02); look(4'd2, 1);
        tag = "R5 count";
        ev(1, 0, 0, 0); look(4'd6, 1);
        tag = "R10 ovf";
        ev(0, 0, 0, 1); look(4'd2, 1);
        ev(1, 0, 0, 0);
        tag = "R4 restart ignored";
        wr(4'd1, 8'h02); look(4'd6, 1);
        tag = "R6 end";
        ev(1, 0, 0, 0); look(4'd2, 2); look(4'd1, 1);
        tag = "R12 idle lines";
        look(4'd6, 1); ev(1, 0, 0, 0); ev(1, 0, 0, 0); look(4'd6, 1);

        tag = "R7 pause";
        wr(4'd2, 8'hFF);
        wr(4'd1, 8'h0A); look(4'd6, 1);
        ev(1, 0, 0, 0); ev(1, 0, 0, 0); ev(1, 0, 0, 0);
        look(4'd2, 2); look(4'd6, 1);
        wr(4'd1, 8'h0A); look(4'd6, 1);
        ev(1, 0, 0, 0); ev(1, 0, 0, 0); ev(1, 0, 0, 0);
        look(4'd2, 2);

        tag = "R8 rewrite";
        wr(4'd2, 8'hFF);
        wr(4'd1, 8'h02);
        look(4'd4, 1);
        wr(4'd4, 8'h05); wr(4'd5, 8'h00); look(4'd4, 1);
        wr(4'd4, 8'hFF); wr(4'd5, 8'hFF); look(4'd5, 1);
        wr(4'd4, 8'h06); wr(4'd5, 8'h00); look(4'd4, 1);
        wr(4'd4, 8'h09); wr(4'd5, 8'h00); look(4'd4, 1);
        wr(4'd4, 8'h00); wr(4'd5, 8'h00); look(4'd4, 1);
        for (int i = 0; i < 6; i++) ev(1, 0, 0, 0);
        look(4'd2, 1);

        tag = "R13 stop";
        wr(4'd2, 8'hFF);
        wr(4'd1, 8'h02); ev(1, 0, 0, 0);
        wr(4'd1, 8'h00); look(4'd2, 2); look(4'd6, 1);

        tag = "R9 marker halt";
        wr(4'd3, 8'h84);
        wr(4'd1, 8'h02); ev(1, 0, 0, 0);
        ev(0, 1, 0, 0); look(4'd2, 2);
        ev(1, 0, 0, 0); look(4'd6, 1);
        wr(4'd3, 8'h04); look(4'd6, 1);
        for (int i = 0; i < 5; i++) ev(1, 0, 0, 0);
        look(4'd2, 2);

        tag = "R1 soft reset";
        wr(4'd3, 8'h0F); wr(4'd1, 8'h06);
        wr(4'd0, 8'h01);
        look(4'd2, 1); look(4'd3, 1); look(4'd4, 1); look(4'd5, 1); look(4'd6, 1); look(4'd1, 1);
        look(4'd2, 2);
    endtask

    initial begin
        fork
            stimulus();
            begin
                repeat (100000) @(posedge clk);
                n_cmp++; n_bad++;
                $display("FAIL R1 watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule